// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The block gathers 64 interrupt request lines, organised as two 32-source banks, and turns them into two processor-facing request outputs: a fast request and a normal request. Each line is watched for a rising edge; an edge marks the source pending, and the pending mark stays until software clears it. Every source has an enable bit and a 3-bit priority. Priorities 0 and 1 send a source to the fast class. Priorities 2 through 7 send it to the normal class. A smaller number is more urgent.

Software reaches the block over a simple single-cycle 32-bit register bus with word addresses. For each class and bank there is a status register whose bits are cleared by writing 1. The bus also reaches two enable registers, eight priority registers with eight sources each, an entry-base register and a control word. A read-only entry register gives the vector address of the most urgent enabled pending normal-class source. It reads as base + (source + 1) * 4, so a handler recovers the source number as (value >> 2) - 1 when the base is zero. It reads as the base alone when nothing qualifies.

Top module: `pvic_top`

## Requirements
- R1: After reset, all pending bits, enables, priorities, entry base and control are zero, every register reads 0, and `fiq_o` and `irq_o` are low.
- R2: A rising edge (0 then 1 on consecutive clocks) on `req_i[i]` sets pending bit i at that clock edge. A level held high does not set it again after it is cleared. An edge on a source that is already pending changes nothing.
- R3: Writing 1 to bit j of the fast status register (0x00 for sources 0-31, 0x04 for 32-63) clears the pending bit of that source only if it is fast-class. The normal status registers (0x08, 0x0C) do the same for normal-class sources. Bits written as 0 are left alone. If an edge arrives in the same cycle as the clear, the source stays pending.
- R4: Fast status bit j of bank b reads as pending AND (priority < 2). Normal status reads as pending AND (priority >= 2). The enable bit has no effect on either.
- R5: The enable registers (0x18 for sources 0-31, 0x1C for 32-63) read back as written. 1 unmasks a source and 0 masks it.
- R6: The priority register at 0x30 + 4r holds source 8r + k in bits [4k+2:4k]. Bit 4k+3 is ignored on write and reads 0.
- R7: `fiq_o` is high exactly when some enabled fast-class source is pending. `irq_o` is high exactly when some enabled normal-class source is pending. Both follow a register write or an edge on the clock edge that takes it.
- R8: The entry register (0x14) reads base + (w + 1) * 4, modulo 2^32. w is the enabled pending normal-class source with the smallest priority number, and the lowest source number wins a tie. When no such source exists, the register reads the base.
- R9: The entry base (0x24) and control (0x20) registers read back the full 32-bit value written. Masking always takes effect at once, whatever the control value.
- R10: Reads of any unmapped or unaligned address return 0, and writes to such an address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 64 | Interrupt request lines, rising-edge sensitive |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| fiq_o | output | 1 | Fast-class request |
| irq_o | output | 1 | Normal-class request |

## Verification
A corrupted pending bit or priority shows up at the ports in the cycle after the faulty edge. It appears as a wrong status bit, a request output in the wrong state, or an entry address pointing at another source. For that reason the bench compares both outputs and the entry register against its own model on every clock, not only at the end of a scenario. Faults in arbitration order or class routing stay hidden until two sources compete. The stimulus therefore forces equal-priority ties, mixed classes and priority rewrites while sources are pending, and sweeps all registers at intervals.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

    localparam int BANK_W      = 32;
    localparam int NUM_BANKS   = 2;
    localparam int NUM_SRC     = BANK_W * NUM_BANKS;
    localparam int PRIO_W      = 3;
    localparam int NIB_W       = 4;
    localparam int FAST_LEVELS = 2;
    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 32;
    localparam int SRC_PER_REG = DATA_W / NIB_W;
    localparam int PRIO_REGS   = NUM_SRC / SRC_PER_REG;
    localparam int IDX_W       = $clog2(NUM_SRC);

    localparam int OFF_FSTAT = 'h00;
    localparam int OFF_ISTAT = 'h08;
    localparam int OFF_ENTRY = 'h14;
    localparam int OFF_EN    = 'h18;
    localparam int OFF_CTRL  = 'h20;
    localparam int OFF_BASE  = 'h24;
    localparam int OFF_PRIO  = 'h30;

    typedef enum logic [2:0] {
        K_NONE, K_FSTAT, K_ISTAT, K_ENTRY, K_EN, K_CTRL, K_BASE, K_PRIO
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [3:0]  idx;
    } reg_sel_t;

    typedef struct packed {
        logic              found;
        logic [IDX_W-1:0]  idx;
        logic [PRIO_W-1:0] prio;
    } win_t;

    function automatic reg_sel_t decode(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        int da;
        da = int'(a);
        s.kind = K_NONE;
        s.idx  = '0;
        if (a[1:0] == 2'b00) begin
            if (da >= OFF_FSTAT && da < OFF_FSTAT + 4*NUM_BANKS) begin
                s.kind = K_FSTAT; s.idx = 4'((da - OFF_FSTAT) >> 2);
            end else if (da >= OFF_ISTAT && da < OFF_ISTAT + 4*NUM_BANKS) begin
                s.kind = K_ISTAT; s.idx = 4'((da - OFF_ISTAT) >> 2);
            end else if (da == OFF_ENTRY) begin
                s.kind = K_ENTRY;
            end else if (da >= OFF_EN && da < OFF_EN + 4*NUM_BANKS) begin
                s.kind = K_EN; s.idx = 4'((da - OFF_EN) >> 2);
            end else if (da == OFF_CTRL) begin
                s.kind = K_CTRL;
            end else if (da == OFF_BASE) begin
                s.kind = K_BASE;
            end else if (da >= OFF_PRIO && da < OFF_PRIO + 4*PRIO_REGS) begin
                s.kind = K_PRIO; s.idx = 4'((da - OFF_PRIO) >> 2);
            end
        end
        return s;
    endfunction

    function automatic logic is_fast(input logic [PRIO_W-1:0] p);
        return int'(p) < FAST_LEVELS;
    endfunction

endpackage

// File: rtl/pvic_pending.sv
module pvic_pending
    import pvic_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int BW = BANK_W,
    localparam int N = NB * BW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] req_q;
    logic [N-1:0] edge_w;

    assign edge_w = req_i & ~req_q;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                req_q[b*BW +: BW]  <= '0;
                pend_o[b*BW +: BW] <= '0;
            end else begin
                req_q[b*BW +: BW]  <= req_i[b*BW +: BW];
                pend_o[b*BW +: BW] <= (pend_o[b*BW +: BW] & ~clr_i[b*BW +: BW])
                                      | edge_w[b*BW +: BW];
            end
        end
    end

    // R2
    rise_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (|edge_w) |=> ((pend_o & $past(edge_w)) == $past(edge_w)));

    // R2
    no_spur_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst) |=> ((pend_o & ~$past(pend_o | edge_w)) == '0));

endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter
    import pvic_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int PW = PRIO_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]    cand_i,
    input  logic [N*PW-1:0] prio_i,
    output win_t            win_o
);

    always_comb begin
        win_o = '0;
        for (int i = 0; i < N; i++) begin
            if (cand_i[i] && (!win_o.found || prio_i[i*PW +: PW] < win_o.prio)) begin
                win_o.found = 1'b1;
                win_o.prio  = prio_i[i*PW +: PW];
                win_o.idx   = IDX_W'(i);
            end
        end
    end

    // R8
    win_cand_chk: assert property (@(posedge clk) disable iff (rst)
        win_o.found |-> cand_i[win_o.idx]);

endmodule

// File: rtl/pvic_top.sv
module pvic_top
    import pvic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               fiq_o,
    output logic               irq_o
);

    reg_sel_t                 sel;
    logic [NUM_SRC-1:0]        pend;
    logic [NUM_SRC-1:0]        en_q;
    logic [NUM_SRC-1:0]        fast_route;
    logic [NUM_SRC-1:0]        clr;
    logic [PRIO_W-1:0]         prio_q [NUM_SRC];
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [DATA_W-1:0]         base_q;
    logic [DATA_W-1:0]         ctrl_q;
    logic [DATA_W-1:0]         entry_val;
    win_t                      win;

    assign sel = decode(bus_addr);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign fast_route[i]               = is_fast(prio_q[i]);
        assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
    end

    always_comb begin
        clr = '0;
        if (bus_we) begin
            if (sel.kind == K_FSTAT)
                clr[int'(sel.idx)*BANK_W +: BANK_W] =
                    bus_wdata & fast_route[int'(sel.idx)*BANK_W +: BANK_W];
            else if (sel.kind == K_ISTAT)
                clr[int'(sel.idx)*BANK_W +: BANK_W] =
                    bus_wdata & ~fast_route[int'(sel.idx)*BANK_W +: BANK_W];
        end
    end

    pvic_pending #(.NB(NUM_BANKS), .BW(BANK_W)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            base_q <= '0;
            ctrl_q <= '0;
            for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= '0;
        end else if (bus_we) begin
            case (sel.kind)
                K_EN:   en_q[int'(sel.idx)*BANK_W +: BANK_W] <= bus_wdata;
                K_BASE: base_q <= bus_wdata;
                K_CTRL: ctrl_q <= bus_wdata;
                K_PRIO: for (int k = 0; k < SRC_PER_REG; k++)
                            prio_q[int'(sel.idx)*SRC_PER_REG + k] <= bus_wdata[k*NIB_W +: PRIO_W];
                default: ;
            endcase
        end
    end

    pvic_arbiter #(.N(NUM_SRC), .PW(PRIO_W)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .cand_i (pend & en_q & ~fast_route),
        .prio_i (prio_flat),
        .win_o  (win)
    );

    assign fiq_o = |(pend & en_q & fast_route);
    assign irq_o = |(pend & en_q & ~fast_route);

    assign entry_val = base_q + (win.found ? ((DATA_W'(win.idx) + 1) << 2) : '0);

    always_comb begin
        bus_rdata = '0;
        case (sel.kind)
            K_FSTAT: bus_rdata = pend[int'(sel.idx)*BANK_W +: BANK_W]
                                 & fast_route[int'(sel.idx)*BANK_W +: BANK_W];
            K_ISTAT: bus_rdata = pend[int'(sel.idx)*BANK_W +: BANK_W]
                                 & ~fast_route[int'(sel.idx)*BANK_W +: BANK_W];
            K_ENTRY: bus_rdata = entry_val;
            K_EN:    bus_rdata = en_q[int'(sel.idx)*BANK_W +: BANK_W];
            K_CTRL:  bus_rdata = ctrl_q;
            K_BASE:  bus_rdata = base_q;
            K_PRIO:  for (int k = 0; k < SRC_PER_REG; k++)
                         bus_rdata[k*NIB_W +: NIB_W] =
                             {1'b0, prio_q[int'(sel.idx)*SRC_PER_REG + k]};
            default: bus_rdata = '0;
        endcase
    end

    // R7
    irq_found_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o == win.found);

    // R7
    fiq_src_chk: assert property (@(posedge clk) disable iff (rst)
        fiq_o |-> (|(pend & en_q)));

    // R8
    entry_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_o |-> (entry_val == base_q));

endmodule

// File: tb/pvic_top_test.sv
module pvic_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] req_i = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fiq_o, irq_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    int          mpend [64];
    int          men   [64];
    int          mprio [64];
    int          mprev [64];
    logic [31:0] mbase, mctrl;

    always #5 clk = ~clk;

    pvic_top uut (
        .clk(clk), .rst(rst), .req_i(req_i), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fiq_o(fiq_o), .irq_o(irq_o)
    );

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] v;
        int best, w;
        v = '0;
        case (a)
            8'h00, 8'h04: for (int j = 0; j < 32; j++) begin
                int s = (a == 8'h04 ? 32 : 0) + j;
                v[j] = (mpend[s] != 0) && (mprio[s] < 2);
            end
            8'h08, 8'h0C: for (int j = 0; j < 32; j++) begin
                int s = (a == 8'h0C ? 32 : 0) + j;
                v[j] = (mpend[s] != 0) && (mprio[s] >= 2);
            end
            8'h14: begin
                best = 8; w = -1;
                for (int i = 0; i < 64; i++)
                    if (mpend[i] != 0 && men[i] != 0 && mprio[i] >= 2 && mprio[i] < best) begin
                        best = mprio[i]; w = i;
                    end
                v = (w < 0) ? mbase : mbase + 32'((w + 1) * 4);
            end
            8'h18, 8'h1C: for (int j = 0; j < 32; j++)
                v[j] = men[(a == 8'h1C ? 32 : 0) + j] != 0;
            8'h20: v = mctrl;
            8'h24: v = mbase;
            default: if (a >= 8'h30 && a <= 8'h4C && a[1:0] == 2'b00)
                for (int k = 0; k < 8; k++)
                    v[k*4 +: 4] = 4'(mprio[(int'(a) - 'h30) / 4 * 8 + k]);
        endcase
        return v;
    endfunction

    function automatic bit model_out(input bit fast);
        bit r = 0;
        for (int i = 0; i < 64; i++)
            if (mpend[i] != 0 && men[i] != 0 && ((mprio[i] < 2) == fast)) r = 1;
        return r;
    endfunction

    task automatic model_clock(input logic [63:0] rq, input bit we,
                               input logic [7:0] a, input logic [31:0] d);
        int eg [64];
        for (int i = 0; i < 64; i++) eg[i] = (rq[i] && mprev[i] == 0) ? 1 : 0;
        if (we && (a == 8'h00 || a == 8'h04 || a == 8'h08 || a == 8'h0C))
            for (int j = 0; j < 32; j++) begin
                int s = ((a == 8'h04 || a == 8'h0C) ? 32 : 0) + j;
                bit fastw = (a == 8'h00 || a == 8'h04);
                if (d[j] && ((mprio[s] < 2) == fastw)) mpend[s] = 0;
            end
        for (int i = 0; i < 64; i++) begin
            if (eg[i] != 0) mpend[i] = 1;
            mprev[i] = rq[i] ? 1 : 0;
        end
        if (we) begin
            case (a)
                8'h18: for (int j = 0; j < 32; j++) men[j] = d[j];
                8'h1C: for (int j = 0; j < 32; j++) men[32 + j] = d[j];
                8'h20: mctrl = d;
                8'h24: mbase = d;
                default: if (a >= 8'h30 && a <= 8'h4C && a[1:0] == 2'b00)
                    for (int k = 0; k < 8; k++)
                        mprio[(int'(a) - 'h30) / 4 * 8 + k] = int'(d[k*4 +: 3]);
            endcase
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        bus_we   = 1'b0;
        bus_addr = a;
        #1;
        check(tag, bus_rdata, model_read(a));
    endtask

    task automatic per_cycle;
        check("R7 fiq_o", {31'b0, fiq_o}, {31'b0, model_out(1'b1)});
        check("R7 irq_o", {31'b0, irq_o}, {31'b0, model_out(1'b0)});
        rd("R8 entry", 8'h14);
    endtask

    task automatic tick(input logic [63:0] rq, input bit we,
                        input logic [7:0] a, input logic [31:0] d);
        req_i = rq; bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_clock(rq, we, a, d);
        #1;
        bus_we = 1'b0;
        per_cycle();
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < 'h54; a += 4) rd(tag, 8'(a));
    endtask

    function automatic logic [31:0] prio_word(input int r);
        logic [31:0] v = '0;
        for (int k = 0; k < 8; k++)
            v[k*4 +: 4] = {1'b1, 3'(((8*r + k) * 5 + 3) % 8)};
        return v;
    endfunction

    initial begin
        #1500000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] r;
        logic [15:0] lfsr;
        for (int i = 0; i < 64; i++) begin mpend[i]=0; men[i]=0; mprio[i]=0; mprev[i]=0; end
        mbase = '0; mctrl = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        per_cycle();
        sweep("R1 reset");

        // R6: priorities with ignored bit 3 set
        for (int q = 0; q < 8; q++) tick('0, 1, 8'(8'h30 + 4*q), prio_word(q));
        sweep("R6 prio");

        // R5: enables
        tick('0, 1, 8'h18, 32'hFFFF_FFFF);
        tick('0, 1, 8'h1C, 32'hFFFF_FFFF);
        rd("R5 en0", 8'h18); rd("R5 en1", 8'h1C);

        // R2, R4: edges on sources 5 and 40 (prio 4 and 3)
        tick(64'h0000_0100_0000_0020, 0, 0, 0);
        tick('0, 0, 0, 0);
        rd("R4 istat0", 8'h08); rd("R4 istat1", 8'h0C); rd("R4 fstat0", 8'h00);

        // R2: held level, cleared, no relatch; second edge while pending
        tick(64'h400, 0, 0, 0);
        tick(64'h400, 1, 8'h08, 32'hFFFF_FFFF);
        tick(64'h400, 0, 0, 0);
        rd("R2 no relatch", 8'h08);
        tick(64'h0000_0100_0000_0000, 0, 0, 0);
        tick(64'h0000_0100_0000_0000, 0, 0, 0);
        rd("R2 repend", 8'h0C);

        // R3: clear all, zero write, clear racing an edge
        for (int a = 0; a < 16; a += 4) tick('0, 1, 8'(a), 32'hFFFF_FFFF);
        sweep("R3 cleared");
        tick(64'h1, 0, 0, 0);
        tick('0, 1, 8'h00, 32'h0);
        rd("R3 zero write", 8'h00);
        tick(64'h2, 1, 8'h00, 32'hFFFF_FFFF);
        rd("R3 edge wins", 8'h00);

        // R8: tie between sources 2 and 10 (same priority)
        tick(64'h400, 0, 0, 0);
        tick(64'h404, 0, 0, 0);
        rd("R8 tie", 8'h14);

        // R9: base and control
        tick('0, 1, 8'h24, 32'hFFFF_FF00);
        tick('0, 1, 8'h20, 32'h0000_0005);
        rd("R9 base", 8'h24); rd("R9 ctrl", 8'h20); rd("R9 entry", 8'h14);

        // R7: masking bank 0 at once
        tick('0, 1, 8'h18, 32'h0);
        tick('0, 1, 8'h1C, 32'h0000_0100);

        // R10: unmapped and unaligned
        tick('0, 1, 8'h10, 32'hFFFF_FFFF);
        tick('0, 1, 8'h25, 32'h1234_5678);
        tick('0, 1, 8'h50, 32'hFFFF_FFFF);
        rd("R10 0x10", 8'h10); rd("R10 0x28", 8'h28); rd("R10 0x50", 8'h50);
        rd("R10 0x25", 8'h25); rd("R10 0x26", 8'h26);
        sweep("R10 sweep");

        // mixed traffic
        lfsr = 16'hACE1;
        r = '0;
        for (int c = 0; c < 4000; c++) begin
            logic [7:0] a;
            bit we;
            r = {r[31:0], 32'($urandom)} & {$urandom, $urandom};
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            we = lfsr[3:0] < 4'd5;
            case (lfsr[7:4] % 8)
                0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
                4: a = lfsr[8] ? 8'h18 : 8'h1C;
                5: a = 8'(8'h30 + 4*(lfsr[11:9]));
                6: a = 8'h24;
                default: a = 8'h14;
            endcase
            tick(r, we, a, $urandom);
            rd("R4 fstat", lfsr[9] ? 8'h04 : 8'h00);
            rd("R4 istat", lfsr[10] ? 8'h0C : 8'h08);
            if (c % 200 == 0) sweep("R6 R5 sweep");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule